// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

This block is a four-bit synchronous counter that steps once per rising clock edge, up or down, in either a full binary range (0 to 15) or a BCD decade range (0 to 9). A high level on the preset enable loads the four jam inputs into the count at once, without waiting for the clock. While preset enable is high, the clock is ignored. An active-low carry-in acts as a count enable.

An active-low carry-out flags the terminal count of the current direction and mode. It is formed combinationally from the count, the mode, the direction and the carry-in. Several stages can therefore share one clock, with each stage's carry-out feeding the carry-in of the next, more significant stage. A synchronous active-high reset clears the count. The preset takes priority over the reset.

Top module: `updown_jam_counter`

## Requirements
- R1: While `preset_en` is 1, `count` takes the value of `jam` without a clock edge. With `jam` = 0 this clears the count to zero.
- R2: `count` changes on a rising `clk` edge only when both `carry_in_n` = 0 and `preset_en` = 0. While either input is 1, the count holds.
- R3: With `bin_sel` = 1 (binary) and `up_sel` = 1 (up), each enabled edge adds one, and 15 wraps to 0.
- R4: With `bin_sel` = 1 and `up_sel` = 0 (down), each enabled edge subtracts one, and 0 wraps to 15.
- R5: With `bin_sel` = 0 (decade), counting up runs 0 to 9 and wraps from 9 to 0. Counting down wraps from 0 to 9.
- R6: In decade mode, a preset value from 10 to 15 goes to 0 on the next enabled edge when counting up. When counting down, it decrements by one.
- R7: `carry_out_n` is 0 exactly when `carry_in_n` = 0 and the count is at its terminal value: the maximum (15 binary, 9 decade) when counting up, or 0 when counting down. It follows input changes in the same cycle, without a clock edge. Otherwise it is 1.
- R8: After `preset_en` falls, the loaded value holds until the next enabled rising edge.
- R9: `rst` = 1 clears the count to 0 on a rising edge when `preset_en` = 0. With `preset_en` = 1, the jam value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| carry_in_n | input | 1 | Active-low count enable / cascade input |
| bin_sel | input | 1 | 1 = binary range, 0 = decade range |
| up_sel | input | 1 | 1 = count up, 0 = count down |
| preset_en | input | 1 | Asynchronous active-high load of `jam` |
| jam | input | 4 | Preset value |
| count | output | 4 | Current count |
| carry_out_n | output | 1 | Active-low terminal-count flag |

## Verification
The clocked assertions assume that `jam` is steady across any clock edge at which `preset_en` is high. They also assume that `preset_en` makes no pulse that starts and ends between two clock edges. The bench therefore changes `jam` only while `preset_en` is low. Each preset pulse is raised in the middle of a cycle and held for at least one clock edge.

The bench changes the control inputs just after a rising edge and samples the outputs one nanosecond after the edge. The preset and carry-out checks are made in the middle of a cycle, so that no clock edge takes part in them.

// File: rtl/udc_pkg.sv
package udc_pkg;

    localparam int CNT_W    = 4;
    localparam int DEC_LAST = 9;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        RADIX_DEC = 1'b0,
        RADIX_BIN = 1'b1
    } radix_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } dir_e;

    typedef struct packed {
        radix_e radix;
        dir_e   dir;
    } ctl_t;

    // Highest value of the selected range.
    function automatic cnt_t last_of(radix_e r);
        return (r == RADIX_BIN) ? '1 : cnt_t'(DEC_LAST);
    endfunction

    // One step in the chosen direction, wrapping at the range ends.
    function automatic cnt_t step(cnt_t c, ctl_t k);
        cnt_t lim;
        lim = last_of(k.radix);
        if (k.dir == DIR_UP)
            return (c >= lim) ? '0 : cnt_t'(c + 1'b1);
        else
            return (c == '0) ? lim : cnt_t'(c - 1'b1);
    endfunction

    // Value at which the carry flag fires for this direction.
    function automatic cnt_t terminal_of(ctl_t k);
        return (k.dir == DIR_UP) ? last_of(k.radix) : '0;
    endfunction

endpackage

// File: rtl/udc_step.sv
module udc_step
    import udc_pkg::*;
(
    input  ctl_t ctl,
    input  cnt_t cur,
    output cnt_t nxt
);

    always_comb begin
        nxt = step(cur, ctl);
    end

    // R5: a legal decade value never leaves the decade range
    always_comb begin
        if (ctl.radix == RADIX_DEC && cur <= cnt_t'(DEC_LAST))
            a_r5_decade_legal: assert (nxt <= cnt_t'(DEC_LAST));
    end

endmodule

// File: rtl/udc_tc.sv
module udc_tc
    import udc_pkg::*;
(
    input  ctl_t ctl,
    input  cnt_t cur,
    input  logic cin_n,
    output logic co_n
);

    logic at_end;

    always_comb begin
        at_end = (cur == terminal_of(ctl));
        co_n   = ~(at_end & ~cin_n);
    end

    // R7: a disabled stage never reports a carry
    always_comb begin
        if (cin_n === 1'b1)
            a_r7_quiet_when_disabled: assert (co_n === 1'b1);
    end

endmodule

// File: rtl/udc_state.sv
module udc_state
    import udc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t jam,
    input  logic adv,
    input  cnt_t nxt,
    output cnt_t cur
);

    always_ff @(posedge clk or posedge load) begin
        if (load)
            cur <= jam;
        else if (rst)
            cur <= '0;
        else if (adv)
            cur <= nxt;
    end

    // R2: no advance while the enable is off
    a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && !$past(adv) && !load) |-> $stable(cur));

    // R1: a held preset keeps the count equal to the jam value
    a_r1_load_follows_jam: assert property (@(posedge clk) disable iff (rst)
        (load && $past(load) && $stable(jam)) |-> (cur == jam));

endmodule

// File: rtl/updown_jam_counter.sv
module updown_jam_counter
    import udc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             carry_in_n,
    input  logic             bin_sel,
    input  logic             up_sel,
    input  logic             preset_en,
    input  logic [CNT_W-1:0] jam,
    output logic [CNT_W-1:0] count,
    output logic             carry_out_n
);

    ctl_t ctl;
    cnt_t cur;
    cnt_t nxt;
    logic adv;

    always_comb begin
        ctl.radix = radix_e'(bin_sel);
        ctl.dir   = dir_e'(up_sel);
        adv       = ~carry_in_n & ~preset_en;
    end

    udc_step step_i (
        .ctl (ctl),
        .cur (cur),
        .nxt (nxt)
    );

    udc_state state_i (
        .clk  (clk),
        .rst  (rst),
        .load (preset_en),
        .jam  (jam),
        .adv  (adv),
        .nxt  (nxt),
        .cur  (cur)
    );

    udc_tc tc_i (
        .ctl   (ctl),
        .cur   (cur),
        .cin_n (carry_in_n),
        .co_n  (carry_out_n)
    );

    assign count = cur;

    // R3: binary up adds one modulo sixteen
    a_r3_bin_up_step: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(preset_en) && !$past(carry_in_n) &&
         $past(bin_sel) && $past(up_sel) && !preset_en)
        |-> (count == cnt_t'($past(count) + 1'b1)));

    // R4: binary down from zero lands on fifteen
    a_r4_bin_down_wrap: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(preset_en) && !$past(carry_in_n) &&
         $past(bin_sel) && !$past(up_sel) && ($past(count) == '0) && !preset_en)
        |-> (count == '1));

endmodule

// File: tb/updown_jam_counter_tb_top.sv
`timescale 1ns/1ps
module updown_jam_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       carry_in_n;
    logic       bin_sel;
    logic       up_sel;
    logic       preset_en;
    logic [3:0] jam;
    logic [3:0] count;
    logic       carry_out_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    updown_jam_counter dut_i (
        .clk         (clk),
        .rst         (rst),
        .carry_in_n  (carry_in_n),
        .bin_sel     (bin_sel),
        .up_sel      (up_sel),
        .preset_en   (preset_en),
        .jam         (jam),
        .count       (count),
        .carry_out_n (carry_out_n)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [3:0] mdl_next(logic [3:0] c, logic bin, logic up);
        logic [3:0] lim;
        lim = bin ? 4'd15 : 4'd9;
        if (up) return (c >= lim) ? 4'd0 : c + 4'd1;
        return (c == 4'd0) ? lim : c - 4'd1;
    endfunction

    function automatic logic mdl_co(logic [3:0] c, logic bin, logic up, logic cin);
        logic [3:0] lim;
        lim = bin ? 4'd15 : 4'd9;
        return !(!cin && (up ? (c == lim) : (c == 4'd0)));
    endfunction

    // Preset mid-cycle, then release mid-cycle.
    task automatic load(input logic [3:0] v);
        jam = v;
        #1 preset_en = 1'b1;
        tick();
        preset_en = 1'b0;
        #2;
    endtask

    task automatic t_reset();
        rst = 1'b1; carry_in_n = 1'b0; bin_sel = 1'b1; up_sel = 1'b1;
        preset_en = 1'b0; jam = 4'd0;
        tick(); tick();
        check("R9 reset count", count, 0);
        check("R9 reset carry", carry_out_n, 1);
        rst = 1'b0;
    endtask

    task automatic t_preset();
        carry_in_n = 1'b1;
        jam = 4'd10;
        #2 preset_en = 1'b1;
        #1 check("R1 async load", count, 10);
        tick();
        check("R1 held load", count, 10);
        preset_en = 1'b0;
        jam = 4'd0;
        #1 preset_en = 1'b1;
        #1 check("R1 clear via jam zero", count, 0);
        carry_in_n = 1'b0;
        tick();
        check("R2 no count while preset high", count, 0);
        preset_en = 1'b0;
    endtask

    task automatic t_release_hold();
        bin_sel = 1'b1; up_sel = 1'b1; carry_in_n = 1'b0;
        load(4'd6);
        check("R8 held after release", count, 6);
        tick();
        check("R8 first enabled edge", count, 7);
    endtask

    task automatic t_inhibit();
        carry_in_n = 1'b1;
        for (int i = 0; i < 3; i++) begin
            tick();
            check("R2 hold with carry_in_n high", count, 7);
        end
        carry_in_n = 1'b0;
    endtask

    task automatic run_seq(input string req, input logic bin, input logic up,
                           input logic [3:0] start, input int n);
        logic [3:0] exp;
        bin_sel = bin; up_sel = up; carry_in_n = 1'b0;
        load(start);
        exp = start;
        for (int i = 0; i < n; i++) begin
            check(req, carry_out_n, mdl_co(exp, bin, up, 1'b0));
            tick();
            exp = mdl_next(exp, bin, up);
            check(req, count, exp);
        end
    endtask

    task automatic t_illegal();
        bin_sel = 1'b0; up_sel = 1'b1; carry_in_n = 1'b0;
        load(4'd12);
        tick();
        check("R6 decade up from 12", count, 0);
        up_sel = 1'b0;
        load(4'd13);
        tick();
        check("R6 decade down from 13", count, 12);
    endtask

    task automatic t_carry();
        carry_in_n = 1'b1;
        bin_sel = 1'b1; up_sel = 1'b1;
        load(4'd15);
        check("R7 gated by carry_in_n", carry_out_n, 1);
        carry_in_n = 1'b0;
        #1 check("R7 binary up at 15", carry_out_n, 0);
        carry_in_n = 1'b1;
        load(4'd9);
        carry_in_n = 1'b0;
        #1 check("R7 binary up at 9", carry_out_n, 1);
        bin_sel = 1'b0;
        #1 check("R7 decade up at 9", carry_out_n, 0);
        up_sel = 1'b0;
        #1 check("R7 down at 9", carry_out_n, 1);
        carry_in_n = 1'b1;
        load(4'd0);
        carry_in_n = 1'b0;
        #1 check("R7 down at 0", carry_out_n, 0);
        up_sel = 1'b1;
        #1 check("R7 up at 0", carry_out_n, 1);
    endtask

    task automatic t_reset_vs_preset();
        carry_in_n = 1'b1;
        jam = 4'd5;
        #1 preset_en = 1'b1;
        rst = 1'b1;
        tick();
        check("R9 preset wins over reset", count, 5);
        preset_en = 1'b0;
        tick();
        check("R9 reset clears", count, 0);
        rst = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #1;
        t_reset();
        t_preset();
        t_release_hold();
        t_inhibit();
        run_seq("R3 binary up", 1'b1, 1'b1, 4'd13, 6);
        run_seq("R4 binary down", 1'b1, 1'b0, 4'd2, 6);
        run_seq("R5 decade up", 1'b0, 1'b1, 4'd7, 12);
        run_seq("R5 decade down", 1'b0, 1'b0, 4'd1, 12);
        t_illegal();
        t_carry();
        t_reset_vs_preset();
        finish_run();
    end

    initial begin
        #1000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        finish_run();
    end

endmodule